// File: doc/BRIEF.md
# System Reset Source Combiner

This block gathers every reason a small microcontroller may need to restart and turns them into one active-low system reset. The requests are a power-on reset input, a watchdog timeout pulse, a CPU lockup indication, a software or debugger restart request, and an active-low external reset pad. The three on-chip requests (watchdog, lockup, software) are each stretched by their own counter, so a single-cycle request still gives a reset of guaranteed minimum length. A new request that arrives while a pulse is running restarts that counter.

The lockup request is ignored while the debug-attached input is high, so a debugger can inspect a stuck core. The external pad is brought into the clock domain by a two-flop synchronizer and a glitch filter. Once the filtered level is low, it holds the system reset for as long as the pad stays low. The block drives a pad output low while an on-chip source or power-on reset is active, so devices on the board can see the restart. A sticky cause register records which sources have fired. A separate power-on reset output serves the domains that a system reset must not touch: debug, power control, real-time clock and key storage. The cause register is itself in that domain.

Top module: `sysrst_combiner`

## Requirements
- R1: While `por_n` is low, `por_rst_n`, `sys_rst_n` and `pin_drv_n` are low and `cause` reads 5'b00001. After `por_n` rises, `por_rst_n` goes high after the second rising clock edge and `sys_rst_n` after the fourth.
- R2: A watchdog, unmasked lockup or software request sampled high at one rising edge drives `sys_rst_n` low just after the next edge. With no further request it stays low for exactly PULSE_CYC+2 cycles.
- R3: A further on-chip request sampled while a pulse is active restarts the minimum width. The low time then ends PULSE_CYC+2 cycles after the latest request edge.
- R4: A lockup request sampled while `dbg_attached` is high causes no reset, no pad drive and no change of `cause[2]`.
- R5: The pad input is sampled through two flops and must read low at FILT_LEN consecutive edges before it takes effect. A low pulse of L >= FILT_LEN cycles drives `sys_rst_n` low for L+2 cycles, starting FILT_LEN+2 edges after the first low sample.
- R6: A pad low pulse shorter than FILT_LEN cycles has no effect on `sys_rst_n` or `cause`.
- R7: `pin_drv_n` is low exactly while an on-chip stretched request was active one edge earlier, and during power-on reset. A pad-only reset never drives it low.
- R8: Cause bit positions: 0 is power-on, 1 is watchdog, 2 is lockup (unmasked), 3 is software, 4 is the pad. A bit is set at the edge where its request is sampled. For the pad, that is the edge where the filtered level turns low.
- R9: `cause_clr` clears, at one edge, every cause bit written with a one. A set arriving at the same edge takes priority over the clear.
- R10: A system reset from any source other than power-on leaves `por_rst_n` high and does not clear `cause`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| wdog_req | input | 1 | Watchdog timeout request |
| lockup_req | input | 1 | CPU lockup indication |
| dbg_attached | input | 1 | Debugger connected; masks lockup |
| soft_req | input | 1 | Software or debugger restart request |
| pad_rst_n | input | 1 | External reset pad level, active low |
| cause_clr | input | 5 | Write-one-to-clear strobe for cause bits |
| por_rst_n | output | 1 | Synchronously released power-on reset |
| sys_rst_n | output | 1 | System reset, active low |
| pin_drv_n | output | 1 | Pad drive, low to signal a reset off-chip |
| cause | output | 5 | Sticky reset-cause bits |

## Verification
The hardest situations to reach from the ports involve timing. One is a second on-chip request that lands inside a running pulse and has to move the release point. Another is a pad pulse exactly one cycle shorter than the filter length, next to one that is exactly long enough. The bench provokes both on purpose: it issues a software request, then a second one about a hundred cycles later, and it sends pad pulses of FILT_LEN-1 and longer. It also places a cause clear on the same edge as a watchdog set. A behavioural model follows request edges and pad history and predicts every output on every cycle.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int N_CAUSE    = 5;
  localparam int CAUSE_POR  = 0;
  localparam int CAUSE_WDOG = 1;
  localparam int CAUSE_LOCK = 2;
  localparam int CAUSE_SOFT = 3;
  localparam int CAUSE_PAD  = 4;
  localparam int N_ONCHIP   = 3;
  localparam logic [N_CAUSE-1:0] CAUSE_RST = N_CAUSE'(1) << CAUSE_POR;
endpackage

// File: rtl/rstc_sync2.sv
module rstc_sync2 #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/rstc_stretch.sv
module rstc_stretch #(
  parameter int LEN = 320
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic active
);
  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = trig | (cnt_q != '0);
    cnt_d  = trig ? CW'(LEN) : cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign active = (cnt_q != '0);
endmodule

// File: rtl/rstc_padfilt.sv
module rstc_padfilt #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic fell
);
  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          lvl_q, lvl_d;

  always_comb begin
    cnt_d = '0;
    lvl_d = lvl_q;
    if (din != lvl_q) begin
      if (cnt_q == CW'(LEN - 1)) lvl_d = din;
      else                       cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign level = lvl_q;
  assign fell  = lvl_q & ~lvl_d;
endmodule

// File: rtl/sysrst_combiner.sv
module sysrst_combiner
  import rstc_pkg::*;
#(
  parameter int PULSE_CYC = 320,
  parameter int FILT_LEN  = 4
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               wdog_req,
  input  logic               lockup_req,
  input  logic               dbg_attached,
  input  logic               soft_req,
  input  logic               pad_rst_n,
  input  logic [N_CAUSE-1:0] cause_clr,
  output logic               por_rst_n,
  output logic               sys_rst_n,
  output logic               pin_drv_n,
  output logic [N_CAUSE-1:0] cause
);
  logic                por_sync_n;
  logic [N_ONCHIP-1:0] oc_trig, oc_act;
  logic                pad_sync, pad_lvl, pad_fell;
  logic                req_d, req_q, oc_d, oc_q;
  logic                sys_arst_n;
  logic [N_CAUSE-1:0]  cause_set, cause_d, cause_q;
  logic                cause_en;

  // Power-on reset: asynchronous assert, two-flop release
  rstc_sync2 #(.RST_VAL(1'b0)) u_por_sync (
    .clk(clk), .arst_n(por_n), .d(1'b1), .q(por_sync_n));

  // On-chip requests, lockup masked by debugger presence
  assign oc_trig[CAUSE_WDOG-1] = wdog_req;
  assign oc_trig[CAUSE_LOCK-1] = lockup_req & ~dbg_attached;
  assign oc_trig[CAUSE_SOFT-1] = soft_req;

  for (genvar g = 0; g < N_ONCHIP; g++) begin : g_str
    rstc_stretch #(.LEN(PULSE_CYC)) u_str (
      .clk(clk), .rst_n(por_sync_n), .trig(oc_trig[g]), .active(oc_act[g]));
  end

  // External pad: synchronize, then filter
  rstc_sync2 #(.RST_VAL(1'b1)) u_pad_sync (
    .clk(clk), .arst_n(por_sync_n), .d(pad_rst_n), .q(pad_sync));

  rstc_padfilt #(.LEN(FILT_LEN)) u_pad_filt (
    .clk(clk), .rst_n(por_sync_n), .din(pad_sync), .level(pad_lvl), .fell(pad_fell));

  // Registered request merge
  always_comb begin
    oc_d  = |oc_act;
    req_d = oc_d | ~pad_lvl;
  end

  always_ff @(posedge clk or negedge por_sync_n) begin
    if (!por_sync_n) begin
      req_q <= 1'b0;
      oc_q  <= 1'b1;
    end else begin
      req_q <= req_d;
      oc_q  <= oc_d;
    end
  end

  // System reset: asynchronous assert from registered request, synchronous release
  assign sys_arst_n = por_sync_n & ~req_q;

  rstc_sync2 #(.RST_VAL(1'b0)) u_sys_sync (
    .clk(clk), .arst_n(sys_arst_n), .d(1'b1), .q(sys_rst_n));

  // Sticky cause register (power-on domain)
  always_comb begin
    cause_set                  = '0;
    cause_set[CAUSE_WDOG]      = oc_trig[CAUSE_WDOG-1];
    cause_set[CAUSE_LOCK]      = oc_trig[CAUSE_LOCK-1];
    cause_set[CAUSE_SOFT]      = oc_trig[CAUSE_SOFT-1];
    cause_set[CAUSE_PAD]       = pad_fell;
    cause_en                   = |{cause_set, cause_clr};
    cause_d                    = (cause_q & ~cause_clr) | cause_set;
  end

  always_ff @(posedge clk or negedge por_sync_n) begin
    if (!por_sync_n)   cause_q <= CAUSE_RST;
    else if (cause_en) cause_q <= cause_d;
  end

  assign por_rst_n = por_sync_n;
  assign pin_drv_n = ~oc_q;
  assign cause     = cause_q;
endmodule

// File: rtl/sysrst_combiner_chk.sv
module sysrst_combiner_chk
  import rstc_pkg::*;
(
  input logic               clk,
  input logic               por_n,
  input logic               wdog_req,
  input logic               lockup_req,
  input logic               dbg_attached,
  input logic               soft_req,
  input logic [N_CAUSE-1:0] cause_clr,
  input logic               por_rst_n,
  input logic               sys_rst_n,
  input logic               pin_drv_n,
  input logic [N_CAUSE-1:0] cause
);
  AST_WDOG_RESETS: assert property (@(posedge clk) disable iff (!por_rst_n)
    wdog_req |=> ##1 !sys_rst_n); // R2

  AST_SOFT_DRIVES_PIN: assert property (@(posedge clk) disable iff (!por_rst_n)
    soft_req |=> ##1 !pin_drv_n); // R7

  AST_LOCKUP_MASKED: assert property (@(posedge clk) disable iff (!por_rst_n)
    (lockup_req && dbg_attached && cause_clr[CAUSE_LOCK]) |=> !cause[CAUSE_LOCK]); // R4

  AST_WDOG_CAUSE: assert property (@(posedge clk) disable iff (!por_rst_n)
    wdog_req |=> cause[CAUSE_WDOG]); // R8

  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!por_rst_n)
    (cause_clr[CAUSE_WDOG] && !wdog_req) |=> !cause[CAUSE_WDOG]); // R9

  AST_POR_ISOLATED: assert property (@(posedge clk) disable iff (!por_n)
    por_rst_n |=> por_rst_n); // R10

  AST_POR_BIT_KEPT: assert property (@(posedge clk) disable iff (!por_rst_n)
    (cause[CAUSE_POR] && !cause_clr[CAUSE_POR]) |=> cause[CAUSE_POR]); // R10
endmodule

bind sysrst_combiner sysrst_combiner_chk u_chk (
  .clk(clk), .por_n(por_n), .wdog_req(wdog_req), .lockup_req(lockup_req),
  .dbg_attached(dbg_attached), .soft_req(soft_req), .cause_clr(cause_clr),
  .por_rst_n(por_rst_n), .sys_rst_n(sys_rst_n), .pin_drv_n(pin_drv_n),
  .cause(cause));

// File: tb/sim_sysrst_combiner.sv
`timescale 1ns/1ps
module sim_sysrst_combiner;
  localparam int P = 320;
  localparam int F = 4;

  logic       clk = 1'b0;
  logic       por_n, wdog_req, lockup_req, dbg_attached, soft_req, pad_rst_n;
  logic [4:0] cause_clr;
  logic       por_rst_n, sys_rst_n, pin_drv_n;
  logic [4:0] cause;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  sysrst_combiner #(.PULSE_CYC(P), .FILT_LEN(F)) u0 (
    .clk(clk), .por_n(por_n), .wdog_req(wdog_req), .lockup_req(lockup_req),
    .dbg_attached(dbg_attached), .soft_req(soft_req), .pad_rst_n(pad_rst_n),
    .cause_clr(cause_clr), .por_rst_n(por_rst_n), .sys_rst_n(sys_rst_n),
    .pin_drv_n(pin_drv_n), .cause(cause));

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // Behavioural reference model
  bit         mdl_on = 0;
  int         mdl_n;
  int         last_oc;
  bit         act, flow, r0, r1, r2, filt;
  bit         pad_hist [0:F];
  bit [4:0]   m_cause;
  bit         e_sys_low, e_pin_low;

  task automatic model_reset();
    mdl_n = 0; last_oc = -1000000;
    act = 0; flow = 0; r0 = 0; r1 = 0; r2 = 0; filt = 1;
    for (int i = 0; i <= F; i++) pad_hist[i] = 1'b1;
    m_cause = 5'b00001;
    e_sys_low = 1; e_pin_low = 1;
  endtask

  always @(posedge clk) begin
    if (mdl_on) begin
      bit p_act, p_flow, flip, fell;
      bit [4:0] sets;
      mdl_n++;
      p_act = act; p_flow = flow;
      sets = 5'b0;
      if (wdog_req) sets[1] = 1'b1;
      if (lockup_req && !dbg_attached) sets[2] = 1'b1;
      if (soft_req) sets[3] = 1'b1;
      if (sets != 5'b0) last_oc = mdl_n;
      act = (mdl_n >= last_oc) && (mdl_n - last_oc < P);
      flip = 1'b1;
      for (int i = 1; i <= F; i++) if (pad_hist[i] == filt) flip = 1'b0;
      fell = 1'b0;
      if (flip) begin filt = !filt; fell = !filt; end
      for (int i = F; i >= 1; i--) pad_hist[i] = pad_hist[i-1];
      pad_hist[0] = pad_rst_n;
      flow = !filt;
      sets[4] = fell;
      r2 = r1; r1 = r0; r0 = p_act | p_flow;
      e_sys_low = r0 | r1 | r2;
      e_pin_low = p_act;
      m_cause = (m_cause & ~cause_clr) | sets;
    end
  end

  always @(negedge clk) begin
    if (mdl_on && mdl_n >= 5) begin
      check("R2/R3/R5 sys_rst_n", {31'b0, sys_rst_n}, {31'b0, !e_sys_low});
      check("R7 pin_drv_n", {31'b0, pin_drv_n}, {31'b0, !e_pin_low});
      check("R8/R9 cause", {27'b0, cause}, {27'b0, m_cause});
      check("R10 por_rst_n", {31'b0, por_rst_n}, 32'd1);
    end
  end

  task automatic count_low(input int cycles, output int lows);
    lows = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (!sys_rst_n) lows++;
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got hung expected finish");
    summary();
    $finish;
  end

  initial begin
    int lows;
    por_n = 0; wdog_req = 0; lockup_req = 0; dbg_attached = 0;
    soft_req = 0; pad_rst_n = 1; cause_clr = 5'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 por_rst_n low", {31'b0, por_rst_n}, 32'd0);
    check("R1 sys_rst_n low", {31'b0, sys_rst_n}, 32'd0);
    check("R1 pin_drv_n low", {31'b0, pin_drv_n}, 32'd0);
    check("R1 cause reset", {27'b0, cause}, 32'd1);
    por_n = 1;
    model_reset();
    mdl_on = 1;
    @(negedge clk);
    check("R1 por_rst_n after 1 edge", {31'b0, por_rst_n}, 32'd0);
    @(negedge clk);
    check("R1 por_rst_n after 2 edges", {31'b0, por_rst_n}, 32'd1);
    @(negedge clk);
    check("R1 sys_rst_n after 3 edges", {31'b0, sys_rst_n}, 32'd0);
    @(negedge clk);
    check("R1 sys_rst_n after 4 edges", {31'b0, sys_rst_n}, 32'd1);
    repeat (4) @(negedge clk);

    // R2 single watchdog pulse
    wdog_req = 1; @(negedge clk); wdog_req = 0;
    check("R10 por_rst_n during reset", {31'b0, por_rst_n}, 32'd1);
    count_low(P + 20, lows);
    check("R2 low width", lows, P + 2);
    check("R10 cause kept", {27'b0, cause}, 32'h03);

    // R3 reload by a second software request
    soft_req = 1; @(negedge clk); soft_req = 0;
    count_low(99, lows);
    soft_req = 1; @(negedge clk); soft_req = 0;
    begin
      int more;
      count_low(P + 20, more);
      check("R3 reloaded low width", lows + 1 + more, 100 + P + 2);
    end

    // R4 masked lockup
    dbg_attached = 1;
    lockup_req = 1; @(negedge clk); lockup_req = 0;
    count_low(30, lows);
    check("R4 masked lockup no reset", lows, 0);
    check("R4 masked lockup cause", {31'b0, cause[2]}, 32'd0);
    dbg_attached = 0;
    lockup_req = 1; @(negedge clk); lockup_req = 0;
    count_low(P + 20, lows);
    check("R4 unmasked lockup low width", lows, P + 2);
    check("R8 lockup cause bit", {31'b0, cause[2]}, 32'd1);

    // R9 clear
    cause_clr = 5'b11110; @(negedge clk); cause_clr = 5'b0;
    check("R9 cleared", {27'b0, cause}, 32'd1);

    // R6 glitch shorter than the filter
    pad_rst_n = 0; repeat (F - 1) @(negedge clk); pad_rst_n = 1;
    count_low(30, lows);
    check("R6 glitch no reset", lows, 0);
    check("R6 glitch cause", {31'b0, cause[4]}, 32'd0);

    // R5 pad low for 50 cycles, R7 pin stays high
    pad_rst_n = 0;
    begin
      int pin_low = 0;
      lows = 0;
      for (int i = 0; i < 50; i++) begin
        @(negedge clk);
        if (!sys_rst_n) lows++;
        if (!pin_drv_n) pin_low++;
      end
      pad_rst_n = 1;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (!sys_rst_n) lows++;
        if (!pin_drv_n) pin_low++;
      end
      check("R5 pad low width", lows, 52);
      check("R7 pad never drives pin", pin_low, 0);
    end
    check("R8 pad cause bit", {31'b0, cause[4]}, 32'd1);

    // R9 set wins over clear at the same edge
    wdog_req = 1; cause_clr = 5'b10010; @(negedge clk);
    wdog_req = 0; cause_clr = 5'b0;
    check("R9 set beats clear", {27'b0, cause}, 32'h03);
    repeat (P + 10) @(negedge clk);

    // R1 power-on reset again
    mdl_on = 0;
    por_n = 0; #1;
    check("R1 por again por_rst_n", {31'b0, por_rst_n}, 32'd0);
    check("R1 por again sys_rst_n", {31'b0, sys_rst_n}, 32'd0);
    check("R1 por again pin_drv_n", {31'b0, pin_drv_n}, 32'd0);
    check("R1 por again cause", {27'b0, cause}, 32'd1);
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule